// File: doc/BRIEF.md
# ARINC 429 Transmit Channel

This block turns 32-bit words queued by a host into an ARINC 429 serial stream. Words enter a 32-entry queue through a simple write strobe. A sequencer takes them out one at a time, fixes up the parity bit and shifts them out as return-to-zero pulses on two logic-level lines, one for ones and one for zeros. Those lines feed an external line driver. Bit timing comes from a prescale tick: each bit lasts 10 ticks at the fast rate or 80 ticks at the slow rate, so a 1 MHz tick gives 100 kbit/s or 12.5 kbit/s.

While the hold input is set, the host can fill the queue and nothing goes out. Once hold is released, the queued words leave back to back, each followed by a four-bit quiet gap. A raw-parity input lets a deliberately wrong parity bit reach the line, for self-test of receivers. In loopback mode the main lines stay quiet and the pulses go to two receiver-side copies instead: one copy is true and the other is inverted. A status output flags an empty queue, and a sticky flag records a write that was lost because the queue was full.

Top module: `a429_tx_channel`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_overflow` is 0, and all six line outputs are 0.
- R2: A bit lasts 10 `tick_en` pulses when `fast_sel`=1 and 80 when `fast_sel`=0. The rate is sampled when a word starts. The active pulse lasts the first half of the bit: 5 or 40 ticks.
- R3: A bit of value 1 pulses `line_hi`, and a bit of value 0 pulses `line_lo`. The two lines are never high together. Both are low in the second half of every bit, during gaps and while idle.
- R4: The word is sent in slot order 0..31. Slot k<8 carries word bit 7-k (label byte, most significant bit first). Slot k>=8 carries word bit k, so bit 31 goes last.
- R5: With `raw_parity`=0, transmitted bit 31 is 1 exactly when word bits 30..0 hold an even number of ones (odd parity overall). With `raw_parity`=1, bit 31 is sent as written.
- R6: While `hold`=1, no new word starts and writes are still accepted. A word already on the line finishes.
- R7: Queued words leave in write order. Consecutive words start exactly 36 bit times apart: 32 bits plus a 4-bit gap.
- R8: The queue holds 32 words. `fifo_empty` is 1 when no word is waiting. A word is removed from the queue when its transmission begins.
- R9: A write while 32 words are waiting (and none is being removed) is dropped and sets `fifo_overflow`. The flag stays set until reset.
- R10: With `loop_en`=1, `line_hi`/`line_lo` stay 0. `loopa_hi`/`loopa_lo` carry the pulses unchanged, and `loopb_hi`/`loopb_lo` carry them swapped (inverted data). With `loop_en`=0, all four loop outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle prescale tick that times the serial bits |
| fast_sel | input | 1 | 1 = 10 ticks per bit, 0 = 80 ticks per bit |
| hold | input | 1 | 1 holds off the start of new words |
| raw_parity | input | 1 | 1 sends bit 31 as written instead of computed odd parity |
| loop_en | input | 1 | Routes pulses to the loopback copies and silences the main lines |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 32 | Word to queue |
| fifo_empty | output | 1 | No word waiting in the queue |
| fifo_overflow | output | 1 | Sticky flag: a write was dropped on a full queue |
| line_hi | output | 1 | Main line pulse for a 1 bit |
| line_lo | output | 1 | Main line pulse for a 0 bit |
| loopa_hi | output | 1 | True loopback copy, 1-bit pulse |
| loopa_lo | output | 1 | True loopback copy, 0-bit pulse |
| loopb_hi | output | 1 | Inverted loopback copy, pulses for 0 bits |
| loopb_lo | output | 1 | Inverted loopback copy, pulses for 1 bits |

## Verification
The assertions assume that `hold`, `loop_en` and the write strobe are ordinary synchronous levels. They also assume that `fast_sel` and `raw_parity` change only between words, because the timing and parity checks are tied to the word boundary. The stimulus changes rate, parity mode and loopback routing only after the lines have been quiet for a full gap, and the bench monitor is switched only while the block is idle. Ticks arrive on every second clock, so all pulse widths and start spacings are fixed multiples of the clock that the bench can count.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  localparam int unsigned A429_BITS = 32;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_BITS = 2'd1,
    TX_GAP  = 2'd2
  } tx_state_e;

  // Serial slot to word bit: label byte reversed, the rest in natural order.
  function automatic logic [4:0] a429_wire_pos(input logic [4:0] slot);
    if (slot < 5'd8) return 5'd7 - slot;
    return slot;
  endfunction

  // Replace bit 31 with odd parity unless the raw mode is requested.
  function automatic logic [31:0] a429_seal(input logic [31:0] w, input logic raw);
    if (raw) return w;
    return {~(^w[30:0]), w[30:0]};
  endfunction

endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          take, give;

  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);
  assign give  = pop && !empty;
  assign take  = push && (!full || give);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (take) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (give) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (take && !give)      count <= count + 1'b1;
      else if (give && !take) count <= count - 1'b1;
      if (push && !take) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
  import a429_tx_pkg::*;
#(
  parameter int unsigned FAST_TICKS = 10,
  parameter int unsigned SLOW_TICKS = 80,
  parameter int unsigned GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        fast_sel,
  input  logic        raw_parity,
  input  logic        hold,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_head,
  output logic        pop,
  output logic        busy,
  output logic        word_end,
  output logic        drive_hi,
  output logic        drive_lo
);
  localparam int unsigned MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CW   = $clog2(MAXT * GAP_BITS + 1);
  localparam logic [CW-1:0] F_BIT = CW'(FAST_TICKS);
  localparam logic [CW-1:0] S_BIT = CW'(SLOW_TICKS);
  localparam logic [CW-1:0] F_GAP = CW'(FAST_TICKS * GAP_BITS);
  localparam logic [CW-1:0] S_GAP = CW'(SLOW_TICKS * GAP_BITS);
  localparam logic [4:0]    LAST_SLOT = 5'(A429_BITS - 1);

  tx_state_e   state;
  logic [CW-1:0] cnt;
  logic [4:0]  slot;
  logic [31:0] word_q;
  logic        fast_q;

  logic [CW-1:0] bit_len, gap_len, half_len;
  logic bit_done, gap_done, launch, mark, cur_bit;

  assign bit_len  = fast_q ? F_BIT : S_BIT;
  assign gap_len  = fast_q ? F_GAP : S_GAP;
  assign half_len = bit_len >> 1;
  assign bit_done = (state == TX_BITS) && (cnt == bit_len - 1'b1);
  assign gap_done = (state == TX_GAP) && (cnt == gap_len - 1'b1);
  assign launch   = tick && !hold && !fifo_empty && ((state == TX_IDLE) || gap_done);

  assign pop      = launch;
  assign busy     = (state != TX_IDLE);
  assign word_end = tick && bit_done && (slot == LAST_SLOT);

  assign cur_bit  = word_q[a429_wire_pos(slot)];
  assign mark     = (state == TX_BITS) && (cnt < half_len);
  assign drive_hi = mark && cur_bit;
  assign drive_lo = mark && !cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      cnt    <= '0;
      slot   <= '0;
      word_q <= '0;
      fast_q <= 1'b0;
    end else if (launch) begin
      state  <= TX_BITS;
      cnt    <= '0;
      slot   <= '0;
      word_q <= a429_seal(fifo_head, raw_parity);
      fast_q <= fast_sel;
    end else if (tick) begin
      unique case (state)
        TX_BITS: begin
          if (bit_done) begin
            cnt <= '0;
            if (slot == LAST_SLOT) state <= TX_GAP;
            else                   slot  <= slot + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (gap_done) begin
            state <= TX_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_route.sv
module a429_tx_route #(
  parameter int unsigned COPIES = 2
) (
  input  logic              drive_hi,
  input  logic              drive_lo,
  input  logic              loop_en,
  output logic              line_hi,
  output logic              line_lo,
  output logic [COPIES-1:0] copy_hi,
  output logic [COPIES-1:0] copy_lo
);
  assign line_hi = drive_hi && !loop_en;
  assign line_lo = drive_lo && !loop_en;

  // Odd-numbered copies carry inverted data: the two lines swap.
  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    if (g % 2 == 1) begin : g_inv
      assign copy_hi[g] = drive_lo && loop_en;
      assign copy_lo[g] = drive_hi && loop_en;
    end else begin : g_true
      assign copy_hi[g] = drive_hi && loop_en;
      assign copy_lo[g] = drive_lo && loop_en;
    end
  end
endmodule

// File: rtl/a429_tx_channel.sv
module a429_tx_channel #(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned FAST_TICKS = 10,
  parameter int unsigned SLOW_TICKS = 80,
  parameter int unsigned GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        fast_sel,
  input  logic        hold,
  input  logic        raw_parity,
  input  logic        loop_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        fifo_empty,
  output logic        fifo_overflow,
  output logic        line_hi,
  output logic        line_lo,
  output logic        loopa_hi,
  output logic        loopa_lo,
  output logic        loopb_hi,
  output logic        loopb_lo
);
  logic [31:0] head;
  logic        pop, busy, word_end, drive_hi, drive_lo, full_unused;
  logic [1:0]  copy_hi, copy_lo;

  a429_tx_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_en), .push_data(wr_data), .pop(pop),
    .head(head), .empty(fifo_empty), .full(full_unused),
    .overflow(fifo_overflow)
  );

  a429_tx_seq #(
    .FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS), .GAP_BITS(GAP_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .fast_sel(fast_sel), .raw_parity(raw_parity), .hold(hold),
    .fifo_empty(fifo_empty), .fifo_head(head),
    .pop(pop), .busy(busy), .word_end(word_end),
    .drive_hi(drive_hi), .drive_lo(drive_lo)
  );

  a429_tx_route #(.COPIES(2)) u_route (
    .drive_hi(drive_hi), .drive_lo(drive_lo), .loop_en(loop_en),
    .line_hi(line_hi), .line_lo(line_lo),
    .copy_hi(copy_hi), .copy_lo(copy_lo)
  );

  assign loopa_hi = copy_hi[0];
  assign loopa_lo = copy_lo[0];
  assign loopb_hi = copy_hi[1];
  assign loopb_lo = copy_lo[1];
endmodule

// File: rtl/a429_tx_checker.sv
module a429_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic loop_en,
  input logic pop,
  input logic busy,
  input logic word_end,
  input logic fifo_empty,
  input logic fifo_overflow,
  input logic drive_hi,
  input logic drive_lo,
  input logic line_hi,
  input logic line_lo,
  input logic loopa_hi,
  input logic loopa_lo,
  input logic loopb_hi,
  input logic loopb_lo
);
  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_hi && drive_lo));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!drive_hi && !drive_lo));

  a_r3_gap_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> (busy && !drive_hi && !drive_lo));

  a_r6_hold_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pop);

  a_r8_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);

  a_r10_main_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (!line_hi && !line_lo));

  a_r10_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> !(loopa_hi || loopa_lo || loopb_hi || loopb_lo));
endmodule

bind a429_tx_channel a429_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .loop_en(loop_en),
  .pop(pop), .busy(busy), .word_end(word_end),
  .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
  .drive_hi(drive_hi), .drive_lo(drive_lo),
  .line_hi(line_hi), .line_lo(line_lo),
  .loopa_hi(loopa_hi), .loopa_lo(loopa_lo),
  .loopb_hi(loopb_hi), .loopb_lo(loopb_lo)
);

// File: tb/a429_tx_channel_bench.sv
module a429_tx_channel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic fast_sel = 1'b1, hold = 1'b0, raw_parity = 1'b0, loop_en = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic fifo_empty, fifo_overflow, line_hi, line_lo;
  logic loopa_hi, loopa_lo, loopb_hi, loopb_lo;

  a429_tx_channel u_a429_tx_channel (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fast_sel(fast_sel),
    .hold(hold), .raw_parity(raw_parity), .loop_en(loop_en),
    .wr_en(wr_en), .wr_data(wr_data),
    .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
    .line_hi(line_hi), .line_lo(line_lo),
    .loopa_hi(loopa_hi), .loopa_lo(loopa_lo),
    .loopb_hi(loopb_hi), .loopb_lo(loopb_lo)
  );

  initial forever #4 clk = ~clk;            // 125 MHz
  initial forever @(negedge clk) tick_en = ~tick_en;  // tick every 2 clocks

  int tests = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- monitor / decoder ----------------
  int mon_sel = 0;      // 0 main lines, 1 true copy, 2 inverted copy
  int cur_ticks = 10;   // ticks per bit expected (one tick = 2 clocks)
  logic mon_hi, mon_lo;
  always_comb begin
    case (mon_sel)
      1:       begin mon_hi = loopa_hi; mon_lo = loopa_lo; end
      2:       begin mon_hi = loopb_hi; mon_lo = loopb_lo; end
      default: begin mon_hi = line_hi;  mon_lo = line_lo;  end
    endcase
  end

  logic [31:0] rx_words[$];
  longint rx_starts[$];
  int timing_err = 0, line_rises = 0, loop_rises = 0, bits_got = 0;
  logic prev_act = 1'b0, prev_line = 1'b0, prev_loop = 1'b0;
  logic [31:0] sbits;
  longint rise_t = 0, first_t = 0;

  always @(negedge clk) begin
    logic act, la, lp;
    logic [31:0] w;
    act = mon_hi | mon_lo;
    la  = line_hi | line_lo;
    lp  = loopa_hi | loopa_lo | loopb_hi | loopb_lo;
    if (la && !prev_line) line_rises++;
    if (lp && !prev_loop) loop_rises++;
    prev_line = la;
    prev_loop = lp;
    if (mon_hi && mon_lo) timing_err++;
    if (act && !prev_act) begin
      if (bits_got == 0) first_t = cyc;
      else if (cyc - rise_t != longint'(2 * cur_ticks)) timing_err++;
      rise_t = cyc;
      sbits[bits_got] = mon_hi;
      bits_got++;
      if (bits_got == 32) begin
        for (int k = 0; k < 32; k++) begin
          if (k < 8) w[7-k] = sbits[k];
          else       w[k]   = sbits[k];
        end
        rx_words.push_back(w);
        rx_starts.push_back(first_t);
        bits_got = 0;
      end
    end
    if (!act && prev_act) begin
      if (cyc - rise_t != longint'(cur_ticks)) timing_err++;
    end
    prev_act = act;
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit raw);
    logic par;
    if (raw) return w;
    par = ($countones(w[30:0]) % 2 == 0);
    return {par, w[30:0]};
  endfunction

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_words(input int n, input int limit);
    for (int i = 0; i < limit && rx_words.size() < n; i++) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_rx;
    rx_words.delete();
    rx_starts.delete();
    timing_err = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    @(negedge clk);
    check(fifo_empty == 1'b1, "R1", "empty after reset", 32'(fifo_empty), 32'd1);
    check(fifo_overflow == 1'b0, "R1", "overflow after reset", 32'(fifo_overflow), 32'd0);
    check({line_hi, line_lo, loopa_hi, loopa_lo, loopb_hi, loopb_lo} == 6'b0, "R1",
          "lines after reset",
          32'({line_hi, line_lo, loopa_hi, loopa_lo, loopb_hi, loopb_lo}), 32'd0);
  endtask

  task automatic t_fast;
    logic [31:0] a = 32'h1234_5681, b = 32'h0000_0080;
    fast_sel = 1'b1; cur_ticks = 10; clear_rx();
    push(a);
    wait_words(1, 1000);
    check(rx_words.size() == 1, "R2", "fast word count", 32'(rx_words.size()), 32'd1);
    if (rx_words.size() >= 1)
      check(rx_words[0] == expect_word(a, 0), "R4", "fast word bits/order",
            rx_words[0], expect_word(a, 0));
    check(timing_err == 0, "R2", "fast pulse and bit timing", 32'(timing_err), 32'd0);
    settle(900);
    clear_rx();
    push(b);
    wait_words(1, 1000);
    if (rx_words.size() >= 1)
      check(rx_words[0] == expect_word(b, 0), "R5", "odd parity label-only word",
            rx_words[0], expect_word(b, 0));
    else check(1'b0, "R4", "label-only word missing", 32'd0, 32'd1);
    settle(900);
  endtask

  task automatic t_hold;
    logic [31:0] w[3] = '{32'hCAFE_0011, 32'h0F0F_F0A5, 32'h7654_3210};
    int base;
    fast_sel = 1'b1; cur_ticks = 10; clear_rx();
    hold = 1'b1;
    base = line_rises;
    foreach (w[i]) push(w[i]);
    settle(1500);
    check(line_rises == base, "R6", "no pulses while held", 32'(line_rises - base), 32'd0);
    check(fifo_empty == 1'b0, "R6", "writes accepted while held", 32'(fifo_empty), 32'd0);
    @(negedge clk) hold = 1'b0;
    wait_words(3, 3 * 720 + 400);
    check(rx_words.size() == 3, "R7", "queued word count", 32'(rx_words.size()), 32'd3);
    if (rx_words.size() == 3) begin
      for (int i = 0; i < 3; i++)
        check(rx_words[i] == expect_word(w[i], 0), "R7", "write order",
              rx_words[i], expect_word(w[i], 0));
      check(rx_starts[1] - rx_starts[0] == 720, "R7", "start spacing 36 bits",
            32'(rx_starts[1] - rx_starts[0]), 32'd720);
      check(rx_starts[2] - rx_starts[1] == 720, "R7", "start spacing 36 bits",
            32'(rx_starts[2] - rx_starts[1]), 32'd720);
    end
    check(fifo_empty == 1'b1, "R8", "empty after drain", 32'(fifo_empty), 32'd1);
    check(timing_err == 0, "R3", "pulse shape in burst", 32'(timing_err), 32'd0);
    settle(900);
  endtask

  task automatic t_slow;
    logic [31:0] s = 32'hA5A5_3C96;
    fast_sel = 1'b0; cur_ticks = 80; clear_rx();
    push(s);
    wait_words(1, 32 * 160 + 400);
    if (rx_words.size() >= 1)
      check(rx_words[0] == expect_word(s, 0), "R2", "slow word",
            rx_words[0], expect_word(s, 0));
    else check(1'b0, "R2", "slow word missing", 32'd0, 32'd1);
    check(timing_err == 0, "R2", "slow pulse and bit timing", 32'(timing_err), 32'd0);
    settle(1500);
    fast_sel = 1'b1; cur_ticks = 10;
  endtask

  task automatic t_raw;
    logic [31:0] bad = 32'h8000_0001;
    clear_rx();
    raw_parity = 1'b1;
    push(bad);
    wait_words(1, 1000);
    if (rx_words.size() >= 1)
      check(rx_words[0] == bad, "R5", "raw parity passes bit 31", rx_words[0], bad);
    else check(1'b0, "R5", "raw word missing", 32'd0, 32'd1);
    settle(900);
    raw_parity = 1'b0;
    clear_rx();
    push(bad);
    wait_words(1, 1000);
    if (rx_words.size() >= 1)
      check(rx_words[0] == 32'h0000_0001, "R5", "parity corrected", rx_words[0], 32'h0000_0001);
    else check(1'b0, "R5", "corrected word missing", 32'd0, 32'd1);
    settle(900);
  endtask

  task automatic t_overflow;
    bit seen_extra = 0;
    clear_rx();
    hold = 1'b1;
    for (int i = 0; i < 32; i++) push(32'hA500_0000 + 32'(i));
    check(fifo_overflow == 1'b0, "R9", "no overflow at 32 words", 32'(fifo_overflow), 32'd0);
    push(32'hA500_0020);
    @(negedge clk);
    check(fifo_overflow == 1'b1, "R9", "overflow on 33rd write", 32'(fifo_overflow), 32'd1);
    @(negedge clk) hold = 1'b0;
    wait_words(32, 32 * 720 + 600);
    settle(900);
    check(rx_words.size() == 32, "R8", "32 words drained", 32'(rx_words.size()), 32'd32);
    foreach (rx_words[i]) if (rx_words[i][30:0] == 31'h2500_0020) seen_extra = 1;
    check(!seen_extra, "R9", "dropped word absent", 32'(seen_extra), 32'd0);
    if (rx_words.size() == 32)
      check(rx_words[31] == expect_word(32'hA500_001F, 0), "R8", "last stored word",
            rx_words[31], expect_word(32'hA500_001F, 0));
    check(fifo_overflow == 1'b1, "R9", "overflow sticky", 32'(fifo_overflow), 32'd1);
  endtask

  task automatic t_wrap;
    logic [31:0] w1 = 32'h3344_55AA, w2 = 32'h0011_22F0, w3 = 32'h6E00_0142;
    int base;
    loop_en = 1'b1; mon_sel = 1; clear_rx();
    base = line_rises;
    push(w1);
    wait_words(1, 1000);
    if (rx_words.size() >= 1)
      check(rx_words[0] == expect_word(w1, 0), "R10", "true copy",
            rx_words[0], expect_word(w1, 0));
    else check(1'b0, "R10", "true copy missing", 32'd0, 32'd1);
    settle(900);
    check(line_rises == base, "R10", "main lines quiet in loopback",
          32'(line_rises - base), 32'd0);
    mon_sel = 2; clear_rx();
    push(w2);
    wait_words(1, 1000);
    if (rx_words.size() >= 1)
      check(rx_words[0] == ~expect_word(w2, 0), "R10", "inverted copy",
            rx_words[0], ~expect_word(w2, 0));
    else check(1'b0, "R10", "inverted copy missing", 32'd0, 32'd1);
    settle(900);
    loop_en = 1'b0; mon_sel = 0; clear_rx();
    base = loop_rises;
    push(w3);
    wait_words(1, 1000);
    settle(900);
    check(loop_rises == base, "R10", "loop copies quiet when off",
          32'(loop_rises - base), 32'd0);
    if (rx_words.size() >= 1)
      check(rx_words[0] == expect_word(w3, 0), "R3", "main line after loopback",
            rx_words[0], expect_word(w3, 0));
    else check(1'b0, "R3", "main word missing", 32'd0, 32'd1);
  endtask

  task automatic t_rereset;
    @(negedge clk) rst_n = 1'b0;
    settle(3);
    check(fifo_overflow == 1'b0, "R1", "overflow cleared by reset", 32'(fifo_overflow), 32'd0);
    @(negedge clk) rst_n = 1'b1;
  endtask

  bit done = 0;
  initial begin
    settle(5);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_fast();
    t_hold();
    t_slow();
    t_raw();
    t_overflow();
    t_wrap();
    t_rereset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule